// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sequences synchronous burst reads from a word array of 4M x 16 bits. The host asserts chip enable and pulses an active-low address strobe. On that clock edge the block captures a 22-bit start word address, a burst mode and an initial wait count. It then holds its ready output low for the programmed number of cycles. After that it presents one word address per clock to a storage array, with ready high while the address is valid.

There are four burst modes. Continuous mode walks upward through the whole array and wraps from the top word to word zero. It pauses for two cycles, with ready low, after any word whose low six address bits are 0x3E, and after the top word. The three wrap modes read 8, 16 or 32 words inside the aligned group that holds the start address. They start at the given address, fold back to the group base and stop after one full group. Raising chip enable, asserting reset or strobing a new address ends a burst.

Top module: `burst_seq`

## Requirements
- R1: While rst_n is low, rdy is 0 and word_addr is 0.
- R2: Let E0 be the clock edge at which avd_n is 0 and ce_n is 0, and let W be wait_cfg, with wait_cfg values 0 and 1 treated as 2. rdy stays 0 after edges E0 through E0+W-1. After edge E0+W, rdy is 1 and word_addr equals the captured start address.
- R3: Mode code 00 selects continuous mode. In that mode each clock with rdy high advances word_addr by one, and 0x3FFFFF is followed by 0x000000.
- R4: In continuous mode, a word whose low six bits are 0x3E is followed by exactly two cycles with rdy 0 before the next address appears. The word 0x3FFFFF is treated the same way.
- R5: Mode codes 01, 10 and 11 select wrap groups of 8, 16 and 32 words. The words read are base + ((start + i) mod N) for i = 0..N-1, where base is the start address with its low log2(N) bits cleared. No stall cycles are inserted.
- R6: A wrap burst presents exactly N words. rdy then stays 0 until a new strobe arrives.
- R7: A strobe during any phase of a burst abandons that burst at the same edge. The initial latency of R2 then starts again with the new address, mode and wait count.
- R8: With ce_n high, rdy is 0 from the next edge onward and strobes are ignored. When ce_n returns low, the block stays idle until a strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| avd_n | input | 1 | Active-low address strobe |
| addr_in | input | 22 | Start word address captured on strobe |
| mode_sel | input | 2 | Burst mode: 00 continuous, 01/10/11 wrap 8/16/32 |
| wait_cfg | input | 3 | Initial wait count, 2 to 7 (0 and 1 act as 2) |
| word_addr | output | 22 | Word address presented to the array |
| rdy | output | 1 | High while word_addr holds a valid burst word |

## Verification
The bench sweeps every wait count, including the out-of-range values 0 and 1, against every mode. The short counts would show an off-by-one latency as ready rising one cycle early or late. Continuous runs cross 0x3E, 0x3FFFFE and the top-to-zero rollover. A design that stalls on the wrong offset, stalls for the wrong length or misses the rollover stall would present a word while ready is expected low. Wrap runs start mid-group and at the last word of the array. Carrying into the upper address bits, or running past N words, would show up as a wrong address or as ready staying high. Restart and chip-enable tests catch a design that finishes the old burst or acts on a strobe while deselected.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 22,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          avd_n,
  input  logic [AW-1:0] addr_in,
  input  logic [1:0]    mode_sel,
  input  logic [WW-1:0] wait_cfg,
  output logic [AW-1:0] word_addr,
  output logic          rdy
);
  localparam int CW = 6;
  localparam logic [5:0] BND = 6'h3E;

  typedef enum logic [2:0] {S_IDLE, S_LAT, S_DATA, S_STALL, S_DONE} st_t;

  st_t           st;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] grp_n;
  logic [AW-1:0] wmask;
  logic [WW-1:0] weff;
  logic          strobe, at_bnd, cont;
  logic [AW-1:0] next_lin, next_wrap;

  assign strobe    = !ce_n && !avd_n;
  assign weff      = (wait_cfg < WW'(2)) ? WW'(2) : wait_cfg;
  assign cont      = (mode_q == 2'b00);
  assign at_bnd    = (word_addr[5:0] == BND) || (&word_addr);
  assign next_lin  = word_addr + AW'(1);
  assign wmask     = AW'(grp_n - CW'(1));
  assign next_wrap = (word_addr & ~wmask) | (next_lin & wmask);
  assign rdy       = (st == S_DATA);

  always_comb begin
    case (mode_q)
      2'b01:   grp_n = CW'(8);
      2'b10:   grp_n = CW'(16);
      2'b11:   grp_n = CW'(32);
      default: grp_n = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      word_addr <= '0;
      cnt       <= '0;
      mode_q    <= 2'b00;
    end else if (ce_n) begin
      st <= S_IDLE;
    end else if (strobe) begin
      st        <= S_LAT;
      word_addr <= addr_in;
      mode_q    <= mode_sel;
      cnt       <= CW'(weff) - CW'(1);
    end else begin
      case (st)
        S_LAT:
          if (cnt == '0) st <= S_DATA;
          else           cnt <= cnt - CW'(1);
        S_DATA:
          if (cont) begin
            if (at_bnd) begin
              st  <= S_STALL;
              cnt <= CW'(1);
            end else begin
              word_addr <= next_lin;
            end
          end else if (cnt == grp_n - CW'(1)) begin
            st <= S_DONE;
          end else begin
            cnt       <= cnt + CW'(1);
            word_addr <= next_wrap;
          end
        S_STALL:
          if (cnt == '0) begin
            st        <= S_DATA;
            word_addr <= next_lin;
          end else begin
            cnt <= cnt - CW'(1);
          end
        default: ;
      endcase
    end
  end

  p_strobe_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !rdy);

  p_ce_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rdy);

  p_cont_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy) && cont && !$past(strobe)) |-> (word_addr == $past(word_addr) + AW'(1)));

  p_wrap_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy) && !cont && !$past(strobe)) |-> ((word_addr & ~wmask) == ($past(word_addr) & ~wmask)));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STALL && cnt == CW'(1) && !ce_n && avd_n) |=> (!rdy && $stable(word_addr)));

  p_wrap_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !cont) |-> (cnt < grp_n));
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        avd_n = 1'b1;
  logic [21:0] addr_in = '0;
  logic [1:0]  mode_sel = '0;
  logic [2:0]  wait_cfg = 3'd2;
  logic [21:0] word_addr;
  logic        rdy;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_seq u_burst_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd_n(avd_n), .addr_in(addr_in),
    .mode_sel(mode_sel), .wait_cfg(wait_cfg), .word_addr(word_addr), .rdy(rdy)
  );

  task automatic chk(input string req, input logic [21:0] act, input logic [21:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic [21:0] a, input logic [1:0] m, input logic [2:0] w);
    addr_in = a; mode_sel = m; wait_cfg = w; avd_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    avd_n = 1'b1;
    chk("R2 rdy low after strobe", {21'd0, rdy}, 22'd0);
    for (int j = 1; j < ((w < 3'd2) ? 2 : int'(w)); j++) begin
      tick();
      chk("R2 rdy low in latency", {21'd0, rdy}, 22'd0);
    end
    tick();
  endtask

  task automatic run_cont(input logic [21:0] a, input logic [2:0] w, input int nw);
    logic [21:0] e;
    strobe(a, 2'b00, w);
    e = a;
    for (int i = 0; i < nw; i++) begin
      chk("R3 continuous rdy", {21'd0, rdy}, 22'd1);
      chk("R3 continuous address", word_addr, e);
      tick();
      if (e[5:0] == 6'h3E || e == 22'h3FFFFF) begin
        chk("R4 stall cycle 1", {21'd0, rdy}, 22'd0);
        tick();
        chk("R4 stall cycle 2", {21'd0, rdy}, 22'd0);
        tick();
      end
      e = e + 22'd1;
    end
  endtask

  task automatic run_wrap(input logic [21:0] a, input logic [1:0] m, input logic [2:0] w);
    int n;
    logic [21:0] mk;
    n = (m == 2'b01) ? 8 : (m == 2'b10) ? 16 : 32;
    mk = 22'(n - 1);
    strobe(a, m, w);
    for (int i = 0; i < n; i++) begin
      chk("R5 wrap rdy", {21'd0, rdy}, 22'd1);
      chk("R5 wrap address", word_addr, (a & ~mk) | ((a + 22'(i)) & mk));
      tick();
    end
    for (int i = 0; i < 3; i++) begin
      chk("R6 rdy low after group", {21'd0, rdy}, 22'd0);
      tick();
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    chk("R1 reset rdy", {21'd0, rdy}, 22'd0);
    chk("R1 reset address", word_addr, 22'd0);
    rst_n = 1'b1;
    ce_n = 1'b0;
    tick();
    chk("R8 idle before strobe", {21'd0, rdy}, 22'd0);

    for (int w = 0; w < 8; w++) begin
      run_cont(22'h00003A, 3'(w), 8);
      for (int m = 1; m < 4; m++) begin
        run_wrap(22'h000039, 2'(m), 3'(w));
      end
    end
    run_cont(22'h3FFFFC, 3'd3, 7);
    run_cont(22'h0000BC, 3'd7, 6);
    for (int m = 1; m < 4; m++) begin
      run_wrap(22'h3FFFFF, 2'(m), 3'd2);
      run_wrap(22'h000020, 2'(m), 3'd4);
      run_wrap(22'h12345B, 2'(m), 3'd5);
    end

    // R7: restart mid-burst, including during latency
    run_cont(22'h000100, 3'd2, 3);
    run_wrap(22'h000207, 2'b01, 3'd3);
    strobe(22'h000300, 2'b00, 3'd6);
    run_cont(22'h00043D, 3'd2, 4);
    addr_in = 22'h000500; mode_sel = 2'b00; wait_cfg = 3'd4; avd_n = 1'b0;
    tick();
    avd_n = 1'b1;
    tick();
    run_cont(22'h000600, 3'd2, 2);

    // R8: chip enable high ends burst and blocks strobes
    ce_n = 1'b1;
    tick();
    chk("R8 rdy low after ce high", {21'd0, rdy}, 22'd0);
    addr_in = 22'h000010; avd_n = 1'b0;
    for (int i = 0; i < 9; i++) begin
      tick();
      chk("R8 strobe ignored while deselected", {21'd0, rdy}, 22'd0);
    end
    avd_n = 1'b1;
    ce_n = 1'b0;
    for (int i = 0; i < 9; i++) begin
      tick();
      chk("R8 idle after reselect", {21'd0, rdy}, 22'd0);
    end
    run_wrap(22'h00001D, 2'b10, 3'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule